// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Interface Controller

This block is the digital side of a two-input, 10-bit successive-approximation converter that talks over a three-wire serial link: an active-low select line that also puts the block in shutdown, a serial clock driven by the host, and one data output with an output enable. All three pins are sampled into the block's own clock domain and their edges are found by comparing two register stages. A free-running oscillator enable input stands in for the local conversion clock.

When the select line falls, the level of the serial clock at that moment decides how the conversion is clocked. If the serial clock is low, the host clock runs the conversion: the input is captured on the second falling edge and one result bit is resolved on each following falling edge. If the serial clock is high, the first falling edge captures the input and the local oscillator resolves the bits. The data output stays low until the result is ready, then goes high to flag the end of conversion, and the host reads the rest of the frame.

The result comes from a register-level binary search against the captured 10-bit input value, MSB first. Each frame is three ones, a channel bit, the ten result bits MSB first, and two zero sub-LSB bits; later falling edges give zeros. Input channels alternate with every conversion that reached its capture point. A build-time option gives a single pseudo-differential input: the channel bit is then always 1 and input 0 is always converted.

Top module: `sar_serial_adc_ctrl`

## Requirements
- R1: Immediately after reset the output enable is 0 and the data output is 0.
- R2: A select fall seen while the serial clock is low starts clocked-by-host mode: the data output is enabled and low, and the k-th serial clock falling edge after the select fall presents frame bit k (k = 1..16).
- R3: In clocked-by-host mode the selected input value is captured on the 2nd serial clock falling edge. Changes to the input after that edge do not affect the result, and the ten result bits equal the captured value.
- R4: A select fall seen while the serial clock is high starts self-clocked mode. The first serial clock falling edge captures the input. The data output stays low through the conversion, and it goes high (the end-of-conversion flag, frame bit 1) once ten oscillator enable pulses after the capture have resolved all bits. Each later falling edge presents the next frame bit.
- R5: Frame bit positions: bits 1 to 3 are 1, bit 4 is the channel bit, bits 5 to 14 are the result from bit 9 down to bit 0, and bits 15 and 16 are 0. Every falling edge after bit 16 presents 0.
- R6: While the select line stays low and the block does not signal end of conversion, the data output changes only in response to a serial clock falling edge.
- R7: While the select line is high the output enable is 0 and no conversion is in progress.
- R8: After reset the first conversion uses input 0 (channel bit 0). Each later conversion that reached its capture point switches to the other input (channel bit 1 for input 1).
- R9: With the pseudo-differential option set, the channel bit is always 1 and input 0 is converted on every conversion.
- R10: Raising the select line before the conversion completes aborts it. If the abort happens before the capture point the channel does not advance. If it happens after, the channel does.
- R11: A select fall wins over a serial clock fall seen in the same cycle, which is not counted. Serial clock falling edges during a self-clocked conversion are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Select, active low; high means shutdown |
| sclk_i | input | 1 | Host serial clock |
| osc_tick_i | input | 1 | One-cycle enable pulses of the local conversion oscillator |
| ch0_val_i | input | W (10) | Sampled value presented on input 0 |
| ch1_val_i | input | W (10) | Sampled value presented on input 1 |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Output enable for the serial data pad (0 = high impedance) |

## Verification
Two pairs of events can fall in the same cycle. A select rise can land on the serial clock falling edge that would resolve the next result bit, and a select fall can land on a serial clock fall. The bench drives both pin changes on the same clock edge. It expects the select event to win: the abort disables the output at once and keeps the channel advance from the earlier capture, and the coincident fall is not counted, so the following frame is complete. A cycle-level reference model compares the data output and enable on every clock, and each frame read back is compared with its expected 16-bit word.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_EXT,
    ST_INT_WAIT,
    ST_INT_CONV,
    ST_READ
  } seq_state_e;

  localparam int unsigned LEAD_ONES = 3;
  localparam int unsigned SUB_BITS  = 2;

  function automatic int unsigned frame_len(input int unsigned w);
    return LEAD_ONES + 1 + w + SUB_BITS;
  endfunction

  function automatic int unsigned pos_width(input int unsigned w);
    return $clog2(frame_len(w) + 2);
  endfunction

endpackage

// File: rtl/sar_pin_edge.sv
module sar_pin_edge #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign level_o = s1_q;
  assign fall_o  = s2_q & ~s1_q;

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         abort_i,
  output logic [W-1:0] result_o,
  output logic         last_o
);

  localparam int unsigned IDXW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(W - 1);

  logic [W-1:0]    hold_q;
  logic [W-1:0]    res_q;
  logic [W-1:0]    trial;
  logic [IDXW-1:0] idx_q;
  logic            busy_q;

  always_comb begin
    trial = res_q | (W'(1) << idx_q);
  end

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      hold_q <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      hold_q <= load_val_i;
      res_q  <= '0;
      idx_q  <= TOP_IDX;
      busy_q <= 1'b1;
    end else if (step_i && busy_q) begin
      if (hold_q >= trial) begin
        res_q <= trial;
      end
      if (idx_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign result_o = res_q;
  assign last_o   = step_i & busy_q & (idx_q == '0) & ~abort_i;

  AST_SAR_CONVERGED: assert property (@(posedge clk) disable iff (rst)
    (last_o && !load_i) |=> (res_q == hold_q)); // R3

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !load_i) |=> $stable(res_q) || $past(abort_i)); // R3

endmodule

// File: rtl/sar_frame_shifter.sv
module sar_frame_shifter
  import sar_adc_pkg::*;
#(
  parameter int unsigned W    = 10,
  parameter int unsigned POSW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            eoc_i,
  input  logic            adv_i,
  input  logic            chid_i,
  input  logic [W-1:0]    data_i,
  output logic            dout_o,
  output logic [POSW-1:0] pos_o
);

  localparam int unsigned FLEN    = frame_len(W);
  localparam int unsigned IDXW    = (W > 1) ? $clog2(W) : 1;
  localparam logic [POSW-1:0] POS_MAX = POSW'(FLEN + 1);
  localparam int unsigned DATA_LO = LEAD_ONES + 2;

  logic [POSW-1:0] pos_q;
  logic [POSW-1:0] pos_nxt;
  logic            dout_q;
  logic            bit_nxt;
  logic [IDXW-1:0] didx;

  always_comb begin
    pos_nxt = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
  end

  always_comb begin
    int unsigned p;
    p       = int'(pos_nxt);
    didx    = '0;
    bit_nxt = 1'b0;
    if (p >= 1 && p <= LEAD_ONES) begin
      bit_nxt = 1'b1;
    end else if (p == LEAD_ONES + 1) begin
      bit_nxt = chid_i;
    end else if (p >= DATA_LO && p < DATA_LO + W) begin
      didx    = IDXW'(W - 1 - (p - DATA_LO));
      bit_nxt = data_i[didx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pos_q  <= '0;
      dout_q <= 1'b0;
    end else if (eoc_i) begin
      pos_q  <= POSW'(1);
      dout_q <= 1'b1;
    end else if (adv_i) begin
      pos_q  <= pos_nxt;
      dout_q <= bit_nxt;
    end
  end

  assign dout_o = dout_q;
  assign pos_o  = pos_q;

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_MAX); // R5

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !clear_i && !eoc_i && pos_q >= POSW'(FLEN)) |=> !dout_q); // R5

endmodule

// File: rtl/sar_serial_adc_ctrl.sv
module sar_serial_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned W           = 10,
  parameter bit          PSEUDO_DIFF = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n_i,
  input  logic         sclk_i,
  input  logic         osc_tick_i,
  input  logic [W-1:0] ch0_val_i,
  input  logic [W-1:0] ch1_val_i,
  output logic         dout_o,
  output logic         dout_oe_o
);

  localparam int unsigned POSW = pos_width(W);
  localparam logic [POSW-1:0] POS_CAPTURE   = POSW'(1);
  localparam logic [POSW-1:0] POS_FIRST_BIT = POSW'(2);
  localparam logic [POSW-1:0] POS_LAST_BIT  = POSW'(W + 1);

  logic cs_lvl, cs_fall;
  logic sclk_lvl, sclk_fall;
  logic tick_q;

  seq_state_e      state_q;
  logic            oe_q;
  logic            chan_q;
  logic            chid_q;
  logic            chid_src;
  logic [W-1:0]    sel_val;
  logic [POSW-1:0] pos;
  logic [W-1:0]    result;
  logic            live;
  logic            sample;
  logic            step;
  logic            last;
  logic            eoc;
  logic            adv;
  logic            clear;

  sar_pin_edge #(.INIT(1'b1)) u_cs_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (cs_n_i),
    .level_o (cs_lvl),
    .fall_o  (cs_fall)
  );

  sar_pin_edge #(.INIT(1'b0)) u_sclk_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (sclk_i),
    .level_o (sclk_lvl),
    .fall_o  (sclk_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= osc_tick_i;
    end
  end

  generate
    if (PSEUDO_DIFF) begin : g_pdiff
      assign chid_src = 1'b1;
      assign sel_val  = ch0_val_i;
    end else begin : g_dual
      assign chid_src = chan_q;
      assign sel_val  = chan_q ? ch1_val_i : ch0_val_i;
    end
  endgenerate

  always_comb begin
    live   = ~cs_lvl & ~cs_fall;
    sample = live & sclk_fall &
             (((state_q == ST_EXT) && (pos == POS_CAPTURE)) || (state_q == ST_INT_WAIT));
    step   = live & (((state_q == ST_EXT) && sclk_fall &&
                      (pos >= POS_FIRST_BIT) && (pos <= POS_LAST_BIT)) ||
                     ((state_q == ST_INT_CONV) && tick_q));
    eoc    = live & (state_q == ST_INT_CONV) & last;
    adv    = live & sclk_fall & ((state_q == ST_EXT) || (state_q == ST_READ));
    clear  = cs_lvl | cs_fall;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_lvl) begin
      state_q <= ST_OFF;
    end else if (cs_fall) begin
      state_q <= sclk_lvl ? ST_INT_WAIT : ST_EXT;
    end else begin
      case (state_q)
        ST_INT_WAIT: if (sample) state_q <= ST_INT_CONV;
        ST_INT_CONV: if (eoc)    state_q <= ST_READ;
        default:     state_q <= state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_lvl) begin
      oe_q <= 1'b0;
    end else if (cs_fall) begin
      oe_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= 1'b0;
      chid_q <= 1'b0;
    end else if (sample) begin
      chan_q <= ~chan_q;
      chid_q <= chid_src;
    end
  end

  sar_bit_engine #(.W(W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .load_i     (sample),
    .load_val_i (sel_val),
    .step_i     (step),
    .abort_i    (cs_lvl),
    .result_o   (result),
    .last_o     (last)
  );

  sar_frame_shifter #(.W(W), .POSW(POSW)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .clear_i (clear),
    .eoc_i   (eoc),
    .adv_i   (adv),
    .chid_i  (chid_q),
    .data_i  (result),
    .dout_o  (dout_o),
    .pos_o   (pos)
  );

  assign dout_oe_o = oe_q;

  AST_HIZ_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> (!dout_oe_o && state_q == ST_OFF)); // R7

  AST_DOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_fall && !cs_lvl && !eoc) |=> $stable(dout_o)); // R6

  AST_CHAN_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    sample |=> (chan_q != $past(chan_q))); // R8

  AST_EOC_FLAG_HIGH: assert property (@(posedge clk) disable iff (rst)
    eoc |=> (dout_o && dout_oe_o)); // R4

  AST_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INT_CONV) |-> !dout_o); // R4

  AST_CHID_PDIFF: assert property (@(posedge clk) disable iff (rst)
    (PSEUDO_DIFF && sample) |=> chid_q); // R9

endmodule

// File: tb/sar_serial_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_serial_adc_ctrl_tb_top;

  localparam int W    = 10;
  localparam int H    = 4;
  localparam int TDIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic osc_tick = 1'b0;
  logic [W-1:0] ch0 = '0;
  logic [W-1:0] ch1 = '0;
  logic dout, oe, dout_pd, oe_pd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  sar_serial_adc_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .osc_tick_i(osc_tick),
    .ch0_val_i(ch0), .ch1_val_i(ch1), .dout_o(dout), .dout_oe_o(oe));

  sar_serial_adc_ctrl #(.W(W), .PSEUDO_DIFF(1'b1)) dut_pd (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .osc_tick_i(osc_tick),
    .ch0_val_i(ch0), .ch1_val_i(ch1), .dout_o(dout_pd), .dout_oe_o(oe_pd));

  // oscillator enable pulses
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    osc_tick <= (tcnt == 0);
  end

  // behavioural reference model: 0 off, 1 host-clocked, 2 wait, 3 self conv, 4 read
  int m_st, m_pos, m_ticks, p_st;
  bit m_chan, m_chid, m_oe, m_dout, m_pcs, m_psclk, p_oe, p_dout;
  int m_val;

  function automatic bit fbit(int p, bit chid, int v);
    if (p >= 1 && p <= 3) return 1'b1;
    if (p == 4) return chid;
    if (p >= 5 && p <= 14) return v[14 - p];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    p_st = m_st; p_oe = m_oe; p_dout = m_dout;
    if (rst) begin
      m_st = 0; m_pos = 0; m_chan = 0; m_chid = 0; m_oe = 0; m_dout = 0;
      m_ticks = 0; m_val = 0;
    end else if (cs_n) begin
      m_st = 0; m_oe = 0; m_dout = 0; m_pos = 0;
    end else if (m_pcs) begin
      m_st = sclk ? 2 : 1; m_oe = 1; m_dout = 0; m_pos = 0;
    end else begin
      bit f;
      f = m_psclk && !sclk;
      if ((m_st == 1 || m_st == 4) && f) begin
        if (m_pos < 17) m_pos++;
        if (m_st == 1 && m_pos == 2) begin
          m_val = m_chan ? int'(ch1) : int'(ch0);
          m_chid = m_chan; m_chan = !m_chan;
        end
        m_dout = fbit(m_pos, m_chid, m_val);
      end else if (m_st == 2 && f) begin
        m_val = m_chan ? int'(ch1) : int'(ch0);
        m_chid = m_chan; m_chan = !m_chan;
        m_st = 3; m_ticks = 0;
      end else if (m_st == 3 && osc_tick) begin
        m_ticks++;
        if (m_ticks == W) begin m_st = 4; m_pos = 1; m_dout = 1; end
      end
    end
    m_pcs = rst ? 1'b1 : cs_n;
    m_psclk = rst ? 1'b0 : sclk;
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      checks++;
      if (oe !== p_oe || (p_oe && dout !== p_dout)) begin
        fails++;
        $display("FAIL %s per-cycle: oe=%b dout=%b expected oe=%b dout=%b",
                 (p_st == 0) ? "R7" : (p_st == 1) ? "R2" : (p_st == 4) ? "R5" : "R4",
                 oe, dout, p_oe, p_dout);
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] word(bit chid, logic [W-1:0] v);
    return {3'b111, chid, v, 2'b00};
  endfunction

  task automatic cs_up();
    cs_n = 1'b1;
    wclk(H);
    chk("R7 oe after select high", {30'd0, oe, oe_pd}, 32'd0);
  endtask

  // host-clocked frame; late values written after the capture edge
  task automatic ext_frame(int nf, logic [W-1:0] l0, logic [W-1:0] l1,
                           output logic [31:0] w, output logic [31:0] wp);
    w = '0; wp = '0;
    sclk = 1'b0; wclk(H);
    cs_n = 1'b0; wclk(H);
    chk("R2 enabled and low after select fall", {30'd0, oe, dout}, 32'd2);
    for (int i = 0; i < nf; i++) begin
      sclk = 1'b1; wclk(H);
      sclk = 1'b0; wclk(H);
      w = {w[30:0], dout}; wp = {wp[30:0], dout_pd};
      if (i == 1) begin ch0 = l0; ch1 = l1; end
    end
  endtask

  // self-clocked frame
  task automatic int_frame(bit jitter, output logic [31:0] w, output logic [31:0] wp);
    int n;
    w = '0; wp = '0;
    sclk = 1'b1; wclk(H);
    cs_n = 1'b0; wclk(H);
    chk("R4 enabled and low before capture", {30'd0, oe, dout}, 32'd2);
    sclk = 1'b0; wclk(H);
    sclk = 1'b1;
    if (jitter) begin
      for (int i = 0; i < 5; i++) begin
        wclk(2); sclk = 1'b0; wclk(2); sclk = 1'b1;
      end
      chk("R11 still busy during ignored edges", {31'd0, dout}, 32'd0);
    end
    n = 0;
    while (dout !== 1'b1 && n < 400) begin wclk(1); n++; end
    chk("R4 end-of-conversion flag", {31'd0, dout}, 32'd1);
    chk("R4 conversion length", (n > 40) ? 32'd1 : 32'd0, 32'd1);
    w = {31'd0, dout}; wp = {31'd0, dout_pd};
    for (int i = 0; i < 15; i++) begin
      sclk = 1'b0; wclk(H);
      w = {w[30:0], dout}; wp = {wp[30:0], dout_pd};
      sclk = 1'b1; wclk(H);
    end
  endtask

  logic [31:0] w, wp;

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(1);
    chk("R1 reset outputs", {30'd0, oe, dout}, 32'd0);
    wclk(3);
    cmp_en = 1;

    // host-clocked, input 0, late change ignored, trailing zeros
    ch0 = 10'h2A5; ch1 = 10'h15A;
    ext_frame(19, 10'h000, 10'h15A, w, wp);
    chk("R2 R3 R5 frame input 0", {16'd0, w[18:3]}, {16'd0, word(1'b0, 10'h2A5)});
    chk("R5 trailing zeros", {29'd0, w[2:0]}, 32'd0);
    chk("R9 pseudo-differential frame", {16'd0, wp[18:3]}, {16'd0, word(1'b1, 10'h2A5)});
    cs_up();

    // next conversion switches to input 1
    ext_frame(16, 10'h000, 10'h15A, w, wp);
    chk("R8 frame input 1", w, {16'd0, word(1'b1, 10'h15A)});
    chk("R9 pseudo-differential keeps input 0", wp, {16'd0, word(1'b1, 10'h000)});
    cs_up();

    // abort before capture: channel stays on input 0
    ext_frame(1, 10'h000, 10'h15A, w, wp);
    cs_up();
    ch0 = 10'h3FF;
    ext_frame(16, 10'h3FF, 10'h15A, w, wp);
    chk("R10 no advance on early abort", w, {16'd0, word(1'b0, 10'h3FF)});
    cs_up();

    // abort after capture, select rise on the same cycle as a resolving fall
    ch1 = 10'h0F0;
    ext_frame(5, 10'h3FF, 10'h0F0, w, wp);
    sclk = 1'b1; wclk(H);
    cs_n = 1'b1; sclk = 1'b0;
    wclk(H);
    chk("R10 abort disables output", {31'd0, oe}, 32'd0);
    ch0 = 10'h000;
    ext_frame(16, 10'h000, 10'h0F0, w, wp);
    chk("R10 advance kept after late abort", w, {16'd0, word(1'b0, 10'h000)});
    cs_up();

    // self-clocked, input 1, full scale
    ch1 = 10'h3FF;
    int_frame(1'b0, w, wp);
    chk("R4 self-clocked frame", w, {16'd0, word(1'b1, 10'h3FF)});
    cs_up();

    // self-clocked with serial clock activity during conversion
    ch0 = 10'h1C3;
    int_frame(1'b1, w, wp);
    chk("R11 edges during conversion ignored", w, {16'd0, word(1'b0, 10'h1C3)});
    chk("R9 pseudo-differential self-clocked", wp, {16'd0, word(1'b1, 10'h1C3)});
    cs_up();

    // select fall coincident with a serial clock fall
    ch1 = 10'h201;
    sclk = 1'b1; wclk(H);
    cs_n = 1'b0; sclk = 1'b0;
    wclk(H);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1; wclk(H);
      sclk = 1'b0; wclk(H);
      w = {w[30:0], dout};
    end
    chk("R11 coincident fall not counted", w, {16'd0, word(1'b1, 10'h201)});
    cs_up();

    wclk(4);
    finish_run();
  end

endmodule